// File: doc/BRIEF.md
# Dimension-Ordered Mesh Router Node

This block is one routing node of a two-dimensional mesh interconnect. It has five links: north, east, south, west and a local link to the attached node. Each link carries one transaction per cycle. A transaction is a 64-bit payload, a 32-bit destination address and a multicast flag. The node knows its own row and column coordinates. For every unicast transaction it compares these with the coordinate fields of the destination address and picks exactly one output. The row is resolved first, then the column, and a transaction that matches both is delivered locally.

Each input holds a working register and a shadow register. The upstream stall signal is a registered copy of the shadow-full state, so it travels backwards one hop per cycle, at the same speed as the data moves forward. A transaction offered while the stall is low is always stored and never lost. Each output has its own round-robin arbiter over the five inputs. The arbiter's pointer moves only when the downstream link actually takes the transaction.

A transaction with the multicast flag set spreads away from where it came from. It is also handed to the local link when its full address equals the node's multicast identifier input. Each copy of a multicast transaction is sent independently. The input buffer is freed once every copy has gone out.

Top module: `xy_mesh_router`

## Requirements
- R1: The destination row is address bits [31:26] and the destination column is bits [25:20]. Bits [19:0] never affect routing.
- R2: A unicast transaction whose destination row is greater than the node row leaves on east (index 1). One whose row is smaller leaves on west (index 3). Port indices are north 0, east 1, south 2, west 3, local 4.
- R3: A unicast transaction with an equal row leaves on south (2) when its column is greater, and on north (0) when its column is smaller.
- R4: A unicast transaction whose row and column both equal the node's coordinates leaves on local (4) only.
- R5: A transaction taken at a clock edge appears on its output in the cycle that follows that edge, and not before.
- R6: Each output grants one input per cycle. The search starts at the input after the last one that completed a transfer and wraps around; after reset the search starts at north. While the output's stall is high the grant does not advance.
- R7: `in_wait` of an input rises only when both its working and shadow registers are full. Every transaction offered while `in_wait` is low is delivered exactly once, in order per input and output pair, no matter how the outputs stall.
- R8: A multicast transaction is forwarded by input of arrival. From local it goes to north, east, south and west. From west it goes to east, north and south. From east it goes to west, north and south. From north it goes to south only. From south it goes to north only.
- R9: A multicast transaction is also delivered on local exactly when its 32-bit address equals `mcast_id`.
- R10: The copies of a multicast transaction are sent independently, each once. A stalled output delays only its own copy, and the input is freed after the last copy.
- R11: During and right after reset, no output is valid and no input stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_row | input | 6 | Row coordinate of this node |
| node_col | input | 6 | Column coordinate of this node |
| mcast_id | input | 32 | Multicast identifier matched for local delivery |
| in_vld | input | 5 | Per-input transaction valid |
| in_mc | input | 5 | Per-input multicast flag |
| in_addr | input | 160 | Per-input destination address, 32 bits per port |
| in_data | input | 320 | Per-input payload, 64 bits per port |
| in_wait | output | 5 | Per-input stall back to the sender |
| out_vld | output | 5 | Per-output transaction valid |
| out_mc | output | 5 | Per-output multicast flag |
| out_addr | output | 160 | Per-output destination address |
| out_data | output | 320 | Per-output payload |
| out_wait | input | 5 | Per-output stall from the receiver |

## Verification
Arbitration and pushback fall in the same cycle when several inputs contend for one stalled output while their own shadows fill. The bench loads four inputs toward east, with two transactions on north, and holds east stalled. It checks that north raises `in_wait`, that the granted source stays the same during the stall, and that release yields the exact rotation north, south, west, local, north. Multicast copies and a blocked output also coincide: the north output is stalled during a local-origin multicast. The three free copies must leave at once and the fourth only after release. A long random phase with random stalls on every output checks that each transaction arrives once, on its computed port.

// File: rtl/xymr_pkg.sv
package xymr_pkg;
    parameter int NPORT = 5;
    parameter int AW    = 32;
    parameter int DW    = 64;
    parameter int CW    = 6;
    localparam int PW   = $clog2(NPORT);
    localparam int LOW  = AW - 2 * CW;

    localparam int P_N = 0;
    localparam int P_E = 1;
    localparam int P_S = 2;
    localparam int P_W = 3;
    localparam int P_L = 4;

    typedef struct packed {
        logic          mc;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } flit_t;

    function automatic logic [CW-1:0] f_row(logic [AW-1:0] a);
        return a[AW-1 -: CW];
    endfunction

    function automatic logic [CW-1:0] f_col(logic [AW-1:0] a);
        return a[AW-CW-1 -: CW];
    endfunction

    // output set for a flit that arrived on input src
    function automatic logic [NPORT-1:0] route_mask(flit_t f, logic [CW-1:0] row,
                                                    logic [CW-1:0] col,
                                                    logic [AW-1:0] mid, int src);
        logic [NPORT-1:0] m;
        m = '0;
        if (f.mc) begin
            if (src == P_L) begin
                m[P_N] = 1'b1; m[P_E] = 1'b1; m[P_S] = 1'b1; m[P_W] = 1'b1;
            end else if (src == P_W) begin
                m[P_E] = 1'b1; m[P_N] = 1'b1; m[P_S] = 1'b1;
            end else if (src == P_E) begin
                m[P_W] = 1'b1; m[P_N] = 1'b1; m[P_S] = 1'b1;
            end else if (src == P_N) begin
                m[P_S] = 1'b1;
            end else begin
                m[P_N] = 1'b1;
            end
            if (f.addr == mid) m[P_L] = 1'b1;
        end else if (f_row(f.addr) > row) begin
            m[P_E] = 1'b1;
        end else if (f_row(f.addr) < row) begin
            m[P_W] = 1'b1;
        end else if (f_col(f.addr) > col) begin
            m[P_S] = 1'b1;
        end else if (f_col(f.addr) < col) begin
            m[P_N] = 1'b1;
        end else begin
            m[P_L] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/xymr_inbuf.sv
module xymr_inbuf import xymr_pkg::*; #(
    parameter int SRC = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    node_row,
    input  logic [CW-1:0]    node_col,
    input  logic [AW-1:0]    mcast_id,
    input  logic             in_vld,
    input  flit_t            in_flit,
    output logic             in_wait,
    output flit_t            hd,
    output logic [NPORT-1:0] req,
    input  logic [NPORT-1:0] xfer
);
    logic             hd_v, sh_v, pop, accept;
    flit_t            sh;
    logic [NPORT-1:0] sent, tgt;

    assign tgt     = route_mask(hd, node_row, node_col, mcast_id, SRC);
    assign req     = hd_v ? (tgt & ~sent) : '0;
    assign pop     = hd_v && ((tgt & ~sent & ~xfer) == '0);
    assign accept  = in_vld && !sh_v;
    assign in_wait = sh_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_v <= 1'b0;
            sh_v <= 1'b0;
            sent <= '0;
        end else if (pop) begin
            sent <= '0;
            if (sh_v) begin
                hd   <= sh;
                sh_v <= 1'b0;
            end else if (accept) begin
                hd <= in_flit;
            end else begin
                hd_v <= 1'b0;
            end
        end else begin
            if (hd_v) sent <= sent | xfer;
            if (accept && !hd_v) begin
                hd_v <= 1'b1;
                hd   <= in_flit;
            end else if (accept) begin
                sh_v <= 1'b1;
                sh   <= in_flit;
            end
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        hd_v && !pop |=> hd_v && (hd == $past(hd)));
    assert_shadow_R7: assert property (@(posedge clk) disable iff (rst)
        sh_v |-> hd_v);
    assert_once_R10: assert property (@(posedge clk) disable iff (rst)
        hd_v |-> ((xfer & sent) == '0));
endmodule

// File: rtl/xymr_rrarb.sv
module xymr_rrarb import xymr_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    input  logic             stall,
    output logic [NPORT-1:0] gnt
);
    logic [PW-1:0] ptr, gidx;
    logic          found;
    int            idx;

    always_comb begin
        gnt   = '0;
        gidx  = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 1; k <= NPORT; k++) begin
            idx = (int'(ptr) + k) % NPORT;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                gidx     = PW'(idx);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 ptr <= PW'(NPORT - 1);
        else if (found && !stall) ptr <= gidx;
    end

    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    assert_grant_R6: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));
    assert_subset_R6: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/xy_mesh_router.sv
module xy_mesh_router import xymr_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic [CW-1:0]      node_row,
    input  logic [CW-1:0]      node_col,
    input  logic [AW-1:0]      mcast_id,
    input  logic [NPORT-1:0]   in_vld,
    input  logic [NPORT-1:0]   in_mc,
    input  logic [NPORT*AW-1:0] in_addr,
    input  logic [NPORT*DW-1:0] in_data,
    output logic [NPORT-1:0]   in_wait,
    output logic [NPORT-1:0]   out_vld,
    output logic [NPORT-1:0]   out_mc,
    output logic [NPORT*AW-1:0] out_addr,
    output logic [NPORT*DW-1:0] out_data,
    input  logic [NPORT-1:0]   out_wait
);
    flit_t            in_f  [NPORT];
    flit_t            hd_f  [NPORT];
    flit_t            out_f [NPORT];
    logic [NPORT-1:0] req_in  [NPORT];
    logic [NPORT-1:0] xfer_in [NPORT];
    logic [NPORT-1:0] req_out [NPORT];
    logic [NPORT-1:0] gnt_out [NPORT];

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                req_out[o][i] = req_in[i][o];
                xfer_in[i][o] = gnt_out[o][i] && !out_wait[o];
            end
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign in_f[i] = '{mc: in_mc[i], addr: in_addr[i*AW +: AW], data: in_data[i*DW +: DW]};
        xymr_inbuf #(.SRC(i)) u_buf (
            .clk(clk), .rst(rst), .node_row(node_row), .node_col(node_col),
            .mcast_id(mcast_id), .in_vld(in_vld[i]), .in_flit(in_f[i]),
            .in_wait(in_wait[i]), .hd(hd_f[i]), .req(req_in[i]), .xfer(xfer_in[i])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        xymr_rrarb u_arb (
            .clk(clk), .rst(rst), .req(req_out[o]), .stall(out_wait[o]), .gnt(gnt_out[o])
        );
        always_comb begin
            out_f[o] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_out[o][i]) out_f[o] = hd_f[i];
            end
        end
        assign out_vld[o]            = |gnt_out[o];
        assign out_mc[o]             = out_f[o].mc;
        assign out_addr[o*AW +: AW]  = out_f[o].addr;
        assign out_data[o*DW +: DW]  = out_f[o].data;
    end

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (out_vld == '0) && (in_wait == '0));
    assert_east_R2: assert property (@(posedge clk) disable iff (rst)
        out_vld[P_E] && !out_f[P_E].mc |-> f_row(out_f[P_E].addr) > node_row);
    assert_west_R2: assert property (@(posedge clk) disable iff (rst)
        out_vld[P_W] && !out_f[P_W].mc |-> f_row(out_f[P_W].addr) < node_row);
    assert_north_R3: assert property (@(posedge clk) disable iff (rst)
        out_vld[P_N] && !out_f[P_N].mc |->
            (f_row(out_f[P_N].addr) == node_row) && (f_col(out_f[P_N].addr) < node_col));
    assert_local_R4: assert property (@(posedge clk) disable iff (rst)
        out_vld[P_L] && !out_f[P_L].mc |->
            (f_row(out_f[P_L].addr) == node_row) && (f_col(out_f[P_L].addr) == node_col));
endmodule

// File: tb/sim_xy_mesh_router.sv
module sim_xy_mesh_router;
    import xymr_pkg::*;

    localparam int MYR = 10;
    localparam int MYC = 20;
    localparam int WD  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [CW-1:0]       node_row = CW'(MYR);
    logic [CW-1:0]       node_col = CW'(MYC);
    logic [AW-1:0]       mcast_id = {6'd33, 6'd44, 20'h0ABCD};
    logic [NPORT-1:0]    in_vld = '0, in_mc = '0, out_wait = '0;
    logic [NPORT*AW-1:0] in_addr = '0;
    logic [NPORT*DW-1:0] in_data = '0;
    logic [NPORT-1:0]    in_wait, out_vld, out_mc;
    logic [NPORT*AW-1:0] out_addr;
    logic [NPORT*DW-1:0] out_data;

    xy_mesh_router u0 (
        .clk(clk), .rst(rst), .node_row(node_row), .node_col(node_col),
        .mcast_id(mcast_id), .in_vld(in_vld), .in_mc(in_mc), .in_addr(in_addr),
        .in_data(in_data), .in_wait(in_wait), .out_vld(out_vld), .out_mc(out_mc),
        .out_addr(out_addr), .out_data(out_data), .out_wait(out_wait)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [NPORT-1:0] ow = '0;

    logic [AW-1:0] q_addr [NPORT][16];
    logic [DW-1:0] q_data [NPORT][16];
    logic          q_mc   [NPORT][16];
    int            q_rd   [NPORT];
    int            q_wr   [NPORT];

    int            lg_port [512];
    logic [DW-1:0] lg_data [512];
    logic          lg_mc   [512];
    int            nlog = 0;

    int            exp_port [4096];
    int            got      [4096];

    function automatic logic [AW-1:0] mka(int r, int c, int lo);
        return {6'(r), 6'(c), 20'(lo)};
    endfunction

    function automatic logic [DW-1:0] mkd(int src, int id);
        return {8'(src), 40'd0, 16'(id)};
    endfunction

    function automatic int ref_port(logic [AW-1:0] a);
        int r, c;
        r = int'(a[31:26]);
        c = int'(a[25:20]);
        if (r > MYR) return 1;
        if (r < MYR) return 3;
        if (c > MYC) return 2;
        if (c < MYC) return 0;
        return 4;
    endfunction

    function automatic int cnt(int p, int id);
        int n = 0;
        for (int k = 0; k < nlog; k++)
            if (lg_port[k] == p && int'(lg_data[k][15:0]) == id) n++;
        return n;
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chkeq(string req, string what, longint act, longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(int p, logic mc, logic [AW-1:0] a, logic [DW-1:0] d);
        q_mc[p][q_wr[p] % 16]   = mc;
        q_addr[p][q_wr[p] % 16] = a;
        q_data[p][q_wr[p] % 16] = d;
        q_wr[p]++;
    endtask

    task automatic step();
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) begin
            if (q_wr[p] != q_rd[p]) begin
                in_vld[p]           = 1'b1;
                in_mc[p]            = q_mc[p][q_rd[p] % 16];
                in_addr[p*AW +: AW] = q_addr[p][q_rd[p] % 16];
                in_data[p*DW +: DW] = q_data[p][q_rd[p] % 16];
            end else begin
                in_vld[p] = 1'b0;
                in_mc[p]  = 1'b0;
            end
        end
        out_wait = ow;
        #1;
        for (int p = 0; p < NPORT; p++) begin
            if (out_vld[p] && !out_wait[p] && nlog < 512) begin
                lg_port[nlog] = p;
                lg_data[nlog] = out_data[p*DW +: DW];
                lg_mc[nlog]   = out_mc[p];
                nlog++;
            end
        end
        for (int p = 0; p < NPORT; p++)
            if (in_vld[p] && !in_wait[p]) q_rd[p]++;
        cyc++;
        if (cyc > WD) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, WD);
            summary();
            $finish;
        end
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic route_one(int pin, logic [AW-1:0] a, int expp, int id, string req);
        nlog = 0;
        push(pin, 1'b0, a, mkd(pin, id));
        steps(4);
        chkeq(req, "delivered on expected port", cnt(expp, id), 1);
        chkeq(req, "no other copy", nlog, 1);
    endtask

    initial begin
        int id, lost;
        logic [AW-1:0] a;
        for (int p = 0; p < NPORT; p++) begin q_rd[p] = 0; q_wr[p] = 0; end
        void'($urandom(32'd20240611));

        steps(3);
        chkeq("R11", "out_vld in reset", out_vld, 0);
        chkeq("R11", "in_wait in reset", in_wait, 0);
        rst = 1'b0;
        step();
        chkeq("R11", "out_vld after reset", out_vld, 0);
        chkeq("R11", "in_wait after reset", in_wait, 0);

        // R5 latency: local input to east
        nlog = 0;
        push(4, 1'b0, mka(MYR + 3, 0, 0), mkd(4, 5));
        step();
        chkeq("R5", "not visible in accept cycle", out_vld[1], 0);
        step();
        chkeq("R5", "visible one cycle later", cnt(1, 5), 1);
        steps(2);

        // unicast direction decode
        route_one(4, mka(MYR + 1, 0, 0),       1, 6,  "R2");
        route_one(0, mka(MYR - 4, 63, 7),      3, 7,  "R2");
        route_one(2, mka(MYR, MYC + 5, 0),     2, 8,  "R3");
        route_one(1, mka(MYR, MYC - 1, 3),     0, 9,  "R3");
        route_one(3, mka(MYR, MYC, 0),         4, 10, "R4");
        route_one(4, mka(MYR, MYC, 20'hFFFFF), 4, 11, "R1");
        route_one(0, mka(MYR, MYC + 1, 20'h00000), 2, 12, "R1");

        // R6 round robin with pushback on a stalled east output
        ow = 5'b00010;
        nlog = 0;
        push(0, 1'b0, mka(MYR + 1, 0, 0), mkd(0, 16'h10));
        push(0, 1'b0, mka(MYR + 2, 0, 0), mkd(0, 16'h11));
        push(2, 1'b0, mka(MYR + 1, 0, 0), mkd(2, 16'h20));
        push(3, 1'b0, mka(MYR + 1, 0, 0), mkd(3, 16'h30));
        push(4, 1'b0, mka(MYR + 1, 0, 0), mkd(4, 16'h40));
        steps(3);
        chkeq("R7", "north stalls with both stages full", in_wait[0], 1);
        chkeq("R7", "south not stalled with one entry", in_wait[2], 0);
        chkeq("R6", "first grant goes to north", out_data[1*DW + 56 +: 8], 0);
        steps(2);
        chkeq("R6", "grant held while stalled", out_data[1*DW + 56 +: 8], 0);
        chkeq("R6", "nothing sent while stalled", nlog, 0);
        ow = '0;
        steps(8);
        chkeq("R6", "transfer count", nlog, 5);
        chkeq("R6", "order slot 0", lg_data[0][15:0], 16'h10);
        chkeq("R6", "order slot 1", lg_data[1][15:0], 16'h20);
        chkeq("R6", "order slot 2", lg_data[2][15:0], 16'h30);
        chkeq("R6", "order slot 3", lg_data[3][15:0], 16'h40);
        chkeq("R6", "order slot 4", lg_data[4][15:0], 16'h11);

        // R7 pushback on local loopback
        ow = 5'b10000;
        nlog = 0;
        push(4, 1'b0, mka(MYR, MYC, 1), mkd(4, 16'h51));
        push(4, 1'b0, mka(MYR, MYC, 2), mkd(4, 16'h52));
        push(4, 1'b0, mka(MYR, MYC, 3), mkd(4, 16'h53));
        steps(4);
        chkeq("R7", "in_wait raised", in_wait[4], 1);
        chkeq("R7", "third held upstream", q_wr[4] - q_rd[4], 1);
        chkeq("R7", "nothing delivered", nlog, 0);
        ow = '0;
        steps(8);
        chkeq("R7", "all three delivered", nlog, 3);
        chkeq("R7", "order first", lg_data[0][15:0], 16'h51);
        chkeq("R7", "order second", lg_data[1][15:0], 16'h52);
        chkeq("R7", "order third", lg_data[2][15:0], 16'h53);

        // R8 multicast from local
        a = mka(5, 6, 1);
        nlog = 0;
        push(4, 1'b1, a, mkd(4, 16'h61));
        steps(5);
        for (int p = 0; p < 4; p++) chkeq("R8", "local origin copy", cnt(p, 16'h61), 1);
        chkeq("R8", "no local copy", cnt(4, 16'h61), 0);
        chkeq("R8", "mc flag kept", lg_mc[0], 1);

        nlog = 0;
        push(3, 1'b1, a, mkd(3, 16'h62));
        steps(5);
        chkeq("R8", "from west: east", cnt(1, 16'h62), 1);
        chkeq("R8", "from west: north", cnt(0, 16'h62), 1);
        chkeq("R8", "from west: south", cnt(2, 16'h62), 1);
        chkeq("R8", "from west: copies", nlog, 3);

        nlog = 0;
        push(0, 1'b1, a, mkd(0, 16'h63));
        steps(5);
        chkeq("R8", "from north: south only", cnt(2, 16'h63), 1);
        chkeq("R8", "from north: copies", nlog, 1);

        nlog = 0;
        push(2, 1'b1, a, mkd(2, 16'h66));
        steps(5);
        chkeq("R8", "from south: north only", cnt(0, 16'h66), 1);
        chkeq("R8", "from south: copies", nlog, 1);

        // R9 local match
        nlog = 0;
        push(1, 1'b1, mcast_id, mkd(1, 16'h64));
        steps(5);
        chkeq("R9", "matching id delivered locally", cnt(4, 16'h64), 1);
        chkeq("R9", "from east: west", cnt(3, 16'h64), 1);
        chkeq("R9", "from east: copies", nlog, 4);
        nlog = 0;
        push(1, 1'b1, mcast_id ^ 32'h1, mkd(1, 16'h65));
        steps(5);
        chkeq("R9", "mismatched id not local", cnt(4, 16'h65), 0);

        // R10 partial multicast with north stalled
        ow = 5'b00001;
        nlog = 0;
        push(4, 1'b1, a, mkd(4, 16'h71));
        steps(4);
        for (int p = 1; p < 4; p++) chkeq("R10", "free copy sent", cnt(p, 16'h71), 1);
        chkeq("R10", "stalled copy waits", cnt(0, 16'h71), 0);
        chkeq("R10", "stalled copy still offered", out_vld[0], 1);
        ow = '0;
        steps(3);
        chkeq("R10", "stalled copy sent once", cnt(0, 16'h71), 1);
        chkeq("R10", "total copies", nlog, 4);
        chkeq("R10", "input freed", out_vld, 0);

        // random unicast traffic with random stalls (R2, R3, R4, R7)
        for (int k = 0; k < 4096; k++) begin exp_port[k] = -1; got[k] = 0; end
        id = 1000;
        for (int c = 0; c < 1500; c++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (($urandom % 100) < 25 && (q_wr[p] - q_rd[p]) < 12 && id < 4000) begin
                    a = mka(int'($urandom % 64), int'($urandom % 64), int'($urandom));
                    if (($urandom % 8) == 0) a = mka(MYR, int'($urandom % 64), int'($urandom));
                    exp_port[id] = ref_port(a);
                    push(p, 1'b0, a, mkd(p, id));
                    id++;
                end
            end
            for (int p = 0; p < NPORT; p++) ow[p] = (($urandom % 100) < 30);
            nlog = 0;
            step();
            for (int k = 0; k < nlog; k++) begin
                int pid;
                pid = int'(lg_data[k][15:0]);
                chkeq("R2", "random route port", lg_port[k], exp_port[pid]);
                got[pid]++;
            end
        end
        ow = '0;
        for (int c = 0; c < 80; c++) begin
            nlog = 0;
            step();
            for (int k = 0; k < nlog; k++) begin
                int pid;
                pid = int'(lg_data[k][15:0]);
                chkeq("R3", "drain route port", lg_port[k], exp_port[pid]);
                got[pid]++;
            end
        end
        lost = 0;
        for (int k = 1000; k < id; k++) if (got[k] != 1) lost++;
        chkeq("R7", "random traffic delivered exactly once", lost, 0);
        chkeq("R4", "random phase idle at end", out_vld, 0);

        summary();
        $finish;
    end
endmodule